// File: doc/BRIEF.md
# Split 64-bit Register Access Bridge

This block presents a small bank of 64-bit registers on a 32-bit memory-mapped port. Each wide register spans two consecutive 32-bit word addresses. The word at the even address carries bits 63..32. The word at the odd address carries bits 31..0. Software writes a wide value in two steps. The first step writes the even word, which only stages the upper half. The second step writes the odd word, which commits all 64 bits in one cycle. A single odd-word write is enough when the upper half is zero.

The bank holds one read/write configuration register and a set of free-running 64-bit event counters. The counters track requests and byte volumes and are advanced by strobe and amount inputs.

Reads stay coherent across the two bus cycles. Reading the odd word of a counter returns its low half. In the same cycle the block captures the counter's upper half into a snapshot tagged with that counter. A later even-word read of the same counter returns the snapshot, even if the counter has moved on since. Bit 31 of the configuration low word is a self-clearing software reset.

Top module: `split64_regbank`

## Requirements
- R1: `bus_addr` is a 32-bit word address. Bits `[ADDR_W-1:1]` select the register: index 0 is the configuration register, and indices 1..NUM_CNT are counters 0..NUM_CNT-1. Bit 0 selects the half: 0 gives bits 63..32 and 1 gives bits 31..0. A read of any other index returns 0.
- R2: A write to the even word of index 0 only stages the data, and `cfg_o` keeps its value.
- R3: A write to the odd word of index 0 loads `cfg_o` with {staged word, write data}. The new value is visible in the cycle after the write.
- R4: The staged word is cleared by reset and by every commit, so an odd-word write with no preceding even-word write yields an upper half of zero.
- R5: While `evt_en[i]` is high, counter i adds `evt_amt[i*AMT_W +: AMT_W]` on each clock, modulo 2^64. Writes to counter addresses have no effect.
- R6: An odd-word read of a counter returns its current bits 31..0 and captures its bits 63..32 as a snapshot tagged with that counter. A later even-word read of the same counter returns the snapshot, and the counter keeps counting in the meantime.
- R7: An even-word read of a counter other than the one last captured, or made while no snapshot is held, returns that counter's live bits 63..32.
- R8: Each read returns its data on `bus_rdata` with `bus_rvalid` high exactly one cycle after `bus_rd`. When no read is returned, `bus_rdata` is 0.
- R9: A commit with write-data bit 31 set first loads `cfg_o` as usual. In the following cycle the configuration register, the staged word, every counter and the snapshot are cleared, and the internal reset then drops by itself.
- R10: After `rst_n` is low, `cfg_o`, `bus_rdata`, `bus_rvalid` and every counter read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address (register index and half select) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| bus_rvalid | output | 1 | Read data valid |
| evt_en | input | NUM_CNT | Per-counter increment enable |
| evt_amt | input | NUM_CNT*AMT_W | Per-counter increment amount |
| cfg_o | output | 64 | Committed configuration value |

## Verification
The hardest case to reach is a torn read. It needs a counter whose upper half changes between the odd-word and even-word reads. With unit strobes that would take 2^32 cycles. The stimulus instead drives byte counters with amounts near 2^32, so the carry into the upper half happens within a few cycles. The even-word read is placed after that carry and compared against a model that holds the snapshot separately. Software reset is also driven while counters are active and a snapshot is held. This checks that clearing wins over the increments and the capture in that cycle.

// File: rtl/split64_regbank.sv
module split64_regbank #(
  parameter int ADDR_W  = 6,
  parameter int NUM_CNT = 7,
  parameter int AMT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     bus_rvalid,
  input  logic [NUM_CNT-1:0]       evt_en,
  input  logic [NUM_CNT*AMT_W-1:0] evt_amt,
  output logic [63:0]              cfg_o
);
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] idx;
  logic             lo_half;
  logic             is_cfg, is_cnt;
  logic [63:0]      cfg_q;
  logic [31:0]      stage_q;
  logic             srst_q;
  logic [31:0]      snap_q;
  logic [IDX_W-1:0] tag_q;
  logic             snap_vld;
  logic [63:0]      cnt_q [NUM_CNT];
  logic [63:0]      live;
  logic [31:0]      rd_mux;
  logic             wr_stage, wr_commit, rd_capture;

  assign idx        = bus_addr[ADDR_W-1:1];
  assign lo_half    = bus_addr[0];
  assign is_cfg     = (idx == '0);
  assign is_cnt     = (idx >= IDX_W'(1)) && (idx <= IDX_W'(NUM_CNT));
  assign wr_stage   = bus_wr && is_cfg && !lo_half;
  assign wr_commit  = bus_wr && is_cfg && lo_half;
  assign rd_capture = bus_rd && is_cnt && lo_half;
  assign cfg_o      = cfg_q;

  always_comb begin
    live = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (idx == IDX_W'(i + 1)) live = cnt_q[i];
  end

  always_comb begin
    rd_mux = '0;
    if (is_cfg)
      rd_mux = lo_half ? cfg_q[31:0] : cfg_q[63:32];
    else if (is_cnt) begin
      if (lo_half)                       rd_mux = live[31:0];
      else if (snap_vld && tag_q == idx) rd_mux = snap_q;
      else                               rd_mux = live[63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      stage_q    <= '0;
      srst_q     <= 1'b0;
      snap_q     <= '0;
      tag_q      <= '0;
      snap_vld   <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
      if (srst_q) begin
        cfg_q    <= '0;
        stage_q  <= '0;
        srst_q   <= 1'b0;
        snap_q   <= '0;
        tag_q    <= '0;
        snap_vld <= 1'b0;
      end else begin
        if (wr_stage) stage_q <= bus_wdata;
        if (wr_commit) begin
          cfg_q   <= {stage_q, bus_wdata};
          stage_q <= '0;
          srst_q  <= bus_wdata[31];
        end
        if (rd_capture) begin
          snap_q   <= live[63:32];
          tag_q    <= idx;
          snap_vld <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n || srst_q) cnt_q[g] <= '0;
      else if (evt_en[g])   cnt_q[g] <= cnt_q[g] + 64'(evt_amt[g*AMT_W +: AMT_W]);
    end
  end

  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stage && !srst_q) |=> $stable(cfg_q)); // R2
  AST_COMMIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !srst_q) |=> cfg_q[31:0] == $past(bus_wdata)); // R3
  AST_STAGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !srst_q) |=> stage_q == '0); // R4
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_en[0] && !srst_q) |=> $stable(cnt_q[0])); // R5
  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_capture && !srst_q) |=> $stable(snap_q)); // R6
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R8
  AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!srst_q && cfg_q == '0 && cnt_q[0] == '0)); // R9
endmodule

// File: tb/tb_split64_regbank.sv
`timescale 1ns/1ps
module tb_split64_regbank;
  localparam int ADDR_W = 6, NUM_CNT = 7, AMT_W = 32;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [NUM_CNT-1:0] evt_en = '0;
  logic [NUM_CNT*AMT_W-1:0] evt_amt = '0;
  logic [63:0] cfg_o;

  split64_regbank #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .AMT_W(AMT_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .evt_en(evt_en), .evt_amt(evt_amt), .cfg_o(cfg_o));

  always #2 clk = ~clk;

  bit [63:0] m_cfg, m_cnt [NUM_CNT];
  bit [31:0] m_stage, m_snap, m_rdata;
  int        m_tag;
  bit        m_vld, m_srst, m_rvalid;
  int        vectors = 0, bad = 0;
  bit        done = 0;
  string     req = "R10";

  function automatic bit [ADDR_W-1:0] wa(int i, bit lo);
    return ADDR_W'(i * 2 + (lo ? 1 : 0));
  endfunction

  task automatic model_step();
    int  i  = int'(bus_addr) >> 1;
    bit  lo = bus_addr[0];
    bit [31:0] r = 0;
    if (!rst_n) begin
      m_cfg = 0; m_stage = 0; m_srst = 0; m_snap = 0; m_tag = 0; m_vld = 0;
      m_rdata = 0; m_rvalid = 0;
      for (int k = 0; k < NUM_CNT; k++) m_cnt[k] = 0;
      return;
    end
    if (bus_rd) begin
      if (i == 0) r = lo ? m_cfg[31:0] : m_cfg[63:32];
      else if (i <= NUM_CNT) begin
        if (lo) r = m_cnt[i-1][31:0];
        else if (m_vld && m_tag == i) r = m_snap;
        else r = m_cnt[i-1][63:32];
      end
    end
    m_rvalid = bus_rd;
    m_rdata  = r;
    if (m_srst) begin
      m_cfg = 0; m_stage = 0; m_srst = 0; m_snap = 0; m_tag = 0; m_vld = 0;
      for (int k = 0; k < NUM_CNT; k++) m_cnt[k] = 0;
    end else begin
      if (bus_rd && lo && i >= 1 && i <= NUM_CNT) begin
        m_snap = m_cnt[i-1][63:32]; m_tag = i; m_vld = 1;
      end
      if (bus_wr && i == 0 && !lo) m_stage = bus_wdata;
      else if (bus_wr && i == 0 && lo) begin
        m_cfg = {m_stage, bus_wdata}; m_stage = 0; m_srst = bus_wdata[31];
      end
      for (int k = 0; k < NUM_CNT; k++)
        if (evt_en[k]) m_cnt[k] = m_cnt[k] + 64'(evt_amt[k*AMT_W +: AMT_W]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    vectors++;
    if (bus_rvalid !== m_rvalid || bus_rdata !== m_rdata || cfg_o !== m_cfg) begin
      bad++;
      $display("FAIL %s: rvalid/rdata/cfg actual %0b/%h/%h expected %0b/%h/%h",
               req, bus_rvalid, bus_rdata, cfg_o, m_rvalid, m_rdata, m_cfg);
    end
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(int i, bit lo, bit [31:0] d);
    bus_wr = 1; bus_addr = wa(i, lo); bus_wdata = d; step();
  endtask

  task automatic rd(int i, bit lo);
    bus_rd = 1; bus_addr = wa(i, lo); step();
  endtask

  task automatic set_evt(int k, bit en, bit [31:0] amt);
    evt_en[k] = en; evt_amt[k*AMT_W +: AMT_W] = amt;
  endtask

  initial begin
    @(negedge clk);
    req = "R10"; repeat (3) step();
    rst_n = 1; step();
    for (int k = 1; k <= NUM_CNT; k++) begin rd(k, 1); rd(k, 0); end
    req = "R2";  wr(0, 0, 32'h1234_5678); step();
    req = "R3";  wr(0, 1, 32'h0000_ABCD); step();
    req = "R1";  rd(0, 0); rd(0, 1); rd(20, 0); rd(20, 1); step();
    req = "R4";  wr(0, 1, 32'h0000_0011); rd(0, 0); step();
    req = "R5";
    set_evt(0, 1, 1); set_evt(3, 1, 32'hFFFF_FFF0); set_evt(6, 1, 32'h0000_1000);
    repeat (4) step();
    wr(1, 0, 32'hDEAD_BEEF); wr(4, 1, 32'h5555_5555);
    rd(1, 1); rd(4, 1); rd(4, 0);
    req = "R6";
    rd(4, 1); repeat (5) step(); rd(4, 0); rd(4, 0);
    req = "R7";
    rd(7, 0); rd(4, 0); rd(7, 1); rd(4, 0); rd(7, 0);
    req = "R8";
    bus_rd = 1; bus_wr = 1; bus_addr = wa(0, 1); bus_wdata = 32'h0000_0042; step();
    step();
    req = "R9";
    rd(4, 1);
    wr(0, 0, 32'h0000_00FF); wr(0, 1, 32'h8000_0001);
    step(); step();
    rd(4, 0); rd(1, 1); rd(0, 0); rd(0, 1);
    req = "R6";
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 5);
      for (int k = 0; k < NUM_CNT; k++)
        set_evt(k, 1'($urandom_range(0, 1)), (k >= 3) ? $urandom() : 32'd1);
      bus_addr  = ADDR_W'($urandom_range(0, 2 * NUM_CNT + 3));
      bus_wdata = $urandom() & 32'h7FFF_FFFF;
      if (op == 5 && n % 97 == 0) bus_wdata[31] = 1'b1;
      bus_rd = (op < 3); bus_wr = (op >= 3 && op < 5) || op == 5;
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule